// File: doc/BRIEF.md
# SDRAM Start-up Sequencer

This block sits on the controller side of a four-bank synchronous DRAM. It drives the start-up sequence the memory needs after reset, before any read or write may be issued. From reset onward it holds the clock-enable and data-mask pins high and drives a no-operation command. It keeps doing so for a stabilization pause whose length is worked out from the clock frequency and the required pause time in microseconds.

After the pause it closes every bank with a single precharge, then waits a programmable recovery time. It then issues a configurable number of auto-refresh commands, each followed by its own recovery window. It also loads the mode register with a CAS latency, burst type, burst length and write-burst mode fixed at elaboration, with every reserved bit driven low. A parameter picks whether the refreshes or the mode load come first. When the sequence is complete a ready flag rises and stays high until the next reset. The main controller watches this flag before it takes over the command pins.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is high and during the whole sequence, cke and dqm are 1. Every cycle that is not a precharge, refresh or mode load presents NOP, coded {cs_n,ras_n,cas_n,we_n} = 4'b0111, with addr and ba all zero. ready is 0 until the sequence ends.
- R2: After reset falls, the pause spans exactly P = CLK_MHZ*PAUSE_US cycles of NOP (cycles 0 to P-1). The precharge appears in cycle P.
- R3: The precharge is coded 4'b0010 with addr bit 10 at 1, all other addr bits at 0 and ba at 0, so that all banks close.
- R4: The precharge is followed by exactly T_RP cycles of NOP before the next command.
- R5: Exactly N_REFRESH auto-refresh commands (4'b0111 replaced by 4'b0001, addr and ba zero) are issued. Each is followed by exactly T_RC cycles of NOP.
- R6: The mode load is coded 4'b0000. It carries the burst length code in addr[2:0], the burst type in addr[3], the CAS latency in addr[6:4] and the write-burst mode in addr[9]. addr[8:7], addr[10], addr[11] and every ba bit are 0.
- R7: With REFRESH_FIRST=1, the refreshes follow the precharge recovery and the mode load follows the last refresh recovery. ready rises in the cycle right after the mode load.
- R8: With REFRESH_FIRST=0, the mode load comes right after the precharge recovery and is followed by T_MRD cycles of NOP, then the refreshes. ready rises in the cycle right after the last refresh recovery.
- R9: Once ready is 1 it stays 1 and the command pins stay at NOP until reset.
- R10: Raising reset at any point, including mid-sequence or after ready, returns the outputs to the R1 state in the next cycle. The whole sequence then restarts from the pause when reset falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cke | output | 1 | Memory clock enable, held high |
| dqm | output | 1 | Data mask, held high during start-up |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address pins, carries the all-bank flag and the mode word |
| ba | output | BA_W | Bank address pins |
| ready | output | 1 | High once the sequence has finished |

## Verification
The bench runs two small configurations side by side, one loading the mode register last and one loading it first. It compares every output pin in every cycle with a schedule it works out from the parameters. An off-by-one in the pause, in the precharge recovery or in a refresh recovery therefore shows up as a command in the wrong cycle. A missing or extra refresh shifts every later command. The mode word is checked field by field, so a swapped field or a reserved bit left high gives a wrong address value. A reset raised mid-sequence and another raised after ready catch a design whose refresh count or ready flag survives reset and so shortens or skips the rerun.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdr_cmd_t;

    localparam sdr_cmd_t CMD_NOP     = sdr_cmd_t'(4'b0111);
    localparam sdr_cmd_t CMD_PRECH   = sdr_cmd_t'(4'b0010);
    localparam sdr_cmd_t CMD_REFRESH = sdr_cmd_t'(4'b0001);
    localparam sdr_cmd_t CMD_MODESET = sdr_cmd_t'(4'b0000);

    // position of the all-bank flag during precharge
    localparam int ALLBANK_BIT = 10;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_PRECH,
        ST_PRECH_WAIT,
        ST_REFRESH,
        ST_REFRESH_WAIT,
        ST_MODESET,
        ST_MODE_WAIT,
        ST_READY
    } init_state_e;

    // 12-bit mode word; reserved bits 7, 8, 10, 11 stay zero
    function automatic logic [11:0] mode_word(input logic [2:0] blen,
                                              input logic       btype,
                                              input logic [2:0] clat,
                                              input logic       wsingle);
        logic [11:0] w;
        w       = '0;
        w[2:0]  = blen;
        w[3]    = btype;
        w[6:4]  = clat;
        w[9]    = wsingle;
        return w;
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int CNT_W   = 8,
    parameter int RST_VAL = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= CNT_W'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
    import sdram_init_pkg::*;
#(
    parameter int N_REFRESH     = 2,
    parameter bit REFRESH_FIRST = 1'b1,
    parameter int T_RP          = 2,
    parameter int T_RC          = 6,
    parameter int T_MRD         = 2,
    parameter int CNT_W         = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output init_state_e      state
);
    localparam int RC_W = $clog2(N_REFRESH + 1);

    init_state_e state_q, state_d;
    logic [RC_W-1:0] ref_cnt;
    init_state_e after_prech, after_refs, after_mode;

    // the order of refresh and mode load is fixed at elaboration
    generate
        if (REFRESH_FIRST) begin : g_ref_first
            assign after_prech = ST_REFRESH;
            assign after_refs  = ST_MODESET;
            assign after_mode  = ST_READY;
        end else begin : g_mode_first
            assign after_prech = ST_MODESET;
            assign after_refs  = ST_READY;
            assign after_mode  = ST_MODE_WAIT;
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_PAUSE:        if (tmr_done) state_d = ST_PRECH;
            ST_PRECH:        state_d = ST_PRECH_WAIT;
            ST_PRECH_WAIT:   if (tmr_done) state_d = after_prech;
            ST_REFRESH:      state_d = ST_REFRESH_WAIT;
            ST_REFRESH_WAIT: if (tmr_done)
                                 state_d = (ref_cnt == RC_W'(N_REFRESH)) ? after_refs : ST_REFRESH;
            ST_MODESET:      state_d = after_mode;
            ST_MODE_WAIT:    if (tmr_done) state_d = ST_REFRESH;
            ST_READY:        state_d = ST_READY;
            default:         state_d = ST_PAUSE;
        endcase
    end

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            ST_PRECH: begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_RP - 1);
            end
            ST_REFRESH: begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_RC - 1);
            end
            ST_MODESET: begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_MRD - 1);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PAUSE;
            ref_cnt <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_REFRESH)
                ref_cnt <= ref_cnt + 1'b1;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
    import sdram_init_pkg::*;
#(
    parameter int       ADDR_W         = 12,
    parameter int       BA_W           = 2,
    parameter bit [2:0] CAS_LAT        = 3'd3,
    parameter bit       BURST_TYPE     = 1'b0,
    parameter bit [2:0] BURST_LEN_CODE = 3'd3,
    parameter bit       WRITE_SINGLE   = 1'b0
) (
    input  init_state_e       state,
    output sdr_cmd_t          cmd,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              ready
);
    localparam logic [11:0] MODE_VAL =
        mode_word(BURST_LEN_CODE, BURST_TYPE, CAS_LAT, WRITE_SINGLE);

    always_comb begin
        cmd  = CMD_NOP;
        addr = '0;
        ba   = '0;
        case (state)
            ST_PRECH: begin
                cmd               = CMD_PRECH;
                addr[ALLBANK_BIT] = 1'b1;
            end
            ST_REFRESH: cmd = CMD_REFRESH;
            ST_MODESET: begin
                cmd  = CMD_MODESET;
                addr = ADDR_W'(MODE_VAL);
            end
            default: ;
        endcase
    end

    assign ready = (state == ST_READY);
endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdram_init_pkg::*;
#(
    parameter int       CLK_MHZ        = 100,
    parameter int       PAUSE_US       = 200,
    parameter int       T_RP           = 2,
    parameter int       T_RC           = 6,
    parameter int       T_MRD          = 2,
    parameter int       N_REFRESH      = 2,
    parameter bit       REFRESH_FIRST  = 1'b1,
    parameter int       ADDR_W         = 12,
    parameter int       BA_W           = 2,
    parameter bit [2:0] CAS_LAT        = 3'd3,
    parameter bit       BURST_TYPE     = 1'b0,
    parameter bit [2:0] BURST_LEN_CODE = 3'd3,
    parameter bit       WRITE_SINGLE   = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    output logic              cke,
    output logic              dqm,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              ready
);
    localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
    localparam int MAX_WAIT  = max4(PAUSE_CYC, T_RP, T_RC, T_MRD);
    localparam int CNT_W     = $clog2(MAX_WAIT + 1);

    init_state_e      state;
    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    sdr_cmd_t         cmd;

    sdram_init_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (PAUSE_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sdram_init_fsm #(
        .N_REFRESH     (N_REFRESH),
        .REFRESH_FIRST (REFRESH_FIRST),
        .T_RP          (T_RP),
        .T_RC          (T_RC),
        .T_MRD         (T_MRD),
        .CNT_W         (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tmr_done (tmr_done),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .state    (state)
    );

    sdram_cmd_drive #(
        .ADDR_W         (ADDR_W),
        .BA_W           (BA_W),
        .CAS_LAT        (CAS_LAT),
        .BURST_TYPE     (BURST_TYPE),
        .BURST_LEN_CODE (BURST_LEN_CODE),
        .WRITE_SINGLE   (WRITE_SINGLE)
    ) u_drive (
        .state (state),
        .cmd   (cmd),
        .addr  (addr),
        .ba    (ba),
        .ready (ready)
    );

    // clock enable and mask stay high for the whole start-up
    assign cke   = 1'b1;
    assign dqm   = 1'b1;
    assign cs_n  = cmd.cs_n;
    assign ras_n = cmd.ras_n;
    assign cas_n = cmd.cas_n;
    assign we_n  = cmd.we_n;
endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk #(
    parameter bit REFRESH_FIRST = 1'b1,
    parameter int ADDR_W        = 12,
    parameter int BA_W          = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cke,
    input logic              dqm,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [BA_W-1:0]   ba,
    input logic              ready
);
    logic [3:0] pins;
    assign pins = {cs_n, ras_n, cas_n, we_n};

    // R1
    enables_high_chk: assert property (@(posedge clk) disable iff (rst)
        cke && dqm);

    // R3
    prech_all_banks_chk: assert property (@(posedge clk) disable iff (rst)
        (pins == 4'b0010) |-> (addr[10] && ba == '0));

    // R6
    mode_reserved_low_chk: assert property (@(posedge clk) disable iff (rst)
        (pins == 4'b0000) |-> (addr[8:7] == 2'b00 && addr[11:10] == 2'b00 && ba == '0));

    // R5
    refresh_recovers_chk: assert property (@(posedge clk) disable iff (rst)
        (pins == 4'b0001) |=> (pins == 4'b0111));

    // R9
    ready_holds_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    // R9
    ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> (pins == 4'b0111));

    generate
        if (REFRESH_FIRST) begin : g_ref_first
            // R7
            ready_after_mode_chk: assert property (@(posedge clk) disable iff (rst)
                (pins == 4'b0000) |=> ready);
        end else begin : g_mode_first
            // R8
            mode_before_ready_chk: assert property (@(posedge clk) disable iff (rst)
                (pins == 4'b0000) |=> !ready);
        end
    endgenerate
endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(
    .REFRESH_FIRST (REFRESH_FIRST),
    .ADDR_W        (ADDR_W),
    .BA_W          (BA_W)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .cke   (cke),
    .dqm   (dqm),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .addr  (addr),
    .ba    (ba),
    .ready (ready)
);

// File: tb/tb_sdram_pwrup_seq.sv
module tb_sdram_pwrup_seq;
    // configuration A: refreshes first
    localparam int A_P = 12, A_RP = 2, A_RC = 3, A_MRD = 2, A_N = 2;
    localparam int A_CL = 3, A_BT = 0, A_BL = 3, A_WS = 0;
    // configuration B: mode load first
    localparam int B_P = 9, B_RP = 1, B_RC = 4, B_MRD = 2, B_N = 3;
    localparam int B_CL = 2, B_BT = 1, B_BL = 2, B_WS = 1;
    localparam int RUN_LEN = 36;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        a_cke, a_dqm, a_cs, a_ras, a_cas, a_we, a_rdy;
    logic [11:0] a_addr;
    logic [1:0]  a_ba;
    logic        b_cke, b_dqm, b_cs, b_ras, b_cas, b_we, b_rdy;
    logic [11:0] b_addr;
    logic [1:0]  b_ba;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    sdram_pwrup_seq #(
        .CLK_MHZ(2), .PAUSE_US(6), .T_RP(A_RP), .T_RC(A_RC), .T_MRD(A_MRD),
        .N_REFRESH(A_N), .REFRESH_FIRST(1'b1), .ADDR_W(12), .BA_W(2),
        .CAS_LAT(3'(A_CL)), .BURST_TYPE(1'(A_BT)), .BURST_LEN_CODE(3'(A_BL)),
        .WRITE_SINGLE(1'(A_WS))
    ) dut (
        .clk(clk), .rst(rst), .cke(a_cke), .dqm(a_dqm), .cs_n(a_cs), .ras_n(a_ras),
        .cas_n(a_cas), .we_n(a_we), .addr(a_addr), .ba(a_ba), .ready(a_rdy)
    );

    sdram_pwrup_seq #(
        .CLK_MHZ(1), .PAUSE_US(9), .T_RP(B_RP), .T_RC(B_RC), .T_MRD(B_MRD),
        .N_REFRESH(B_N), .REFRESH_FIRST(1'b0), .ADDR_W(12), .BA_W(2),
        .CAS_LAT(3'(B_CL)), .BURST_TYPE(1'(B_BT)), .BURST_LEN_CODE(3'(B_BL)),
        .WRITE_SINGLE(1'(B_WS))
    ) dut_alt (
        .clk(clk), .rst(rst), .cke(b_cke), .dqm(b_dqm), .cs_n(b_cs), .ras_n(b_ras),
        .cas_n(b_cas), .we_n(b_we), .addr(b_addr), .ba(b_ba), .ready(b_rdy)
    );

    task automatic check(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, actual, expected, $time);
        end
    endtask

    // expected command pins in cycle t after reset release
    function automatic int exp_cmd(input int t, input int p, input int trp, input int trc,
                                   input int tmrd, input int n, input bit rfirst);
        int e, per, rel;
        e   = p + 1 + trp;
        per = 1 + trc;
        if (t < p)  return 4'b0111;
        if (t == p) return 4'b0010;
        if (t < e)  return 4'b0111;
        if (rfirst) begin
            rel = t - e;
            if (rel < n * per) return (rel % per == 0) ? 4'b0001 : 4'b0111;
            if (rel == n * per) return 4'b0000;
            return 4'b0111;
        end
        if (t == e) return 4'b0000;
        rel = t - (e + 1 + tmrd);
        if (rel < 0) return 4'b0111;
        if (rel < n * per) return (rel % per == 0) ? 4'b0001 : 4'b0111;
        return 4'b0111;
    endfunction

    function automatic int exp_rdy(input int t, input int p, input int trp, input int trc,
                                   input int tmrd, input int n, input bit rfirst);
        int e;
        e = p + 1 + trp;
        if (rfirst) return (t >= e + n * (1 + trc) + 1) ? 1 : 0;
        return (t >= e + 1 + tmrd + n * (1 + trc)) ? 1 : 0;
    endfunction

    function automatic int exp_addr(input int cmd, input int cl, input int bt,
                                    input int bl, input int ws);
        if (cmd == 4'b0010) return 1 << 10;
        if (cmd == 4'b0000) return bl + bt * 8 + cl * 16 + ws * 512;
        return 0;
    endfunction

    function automatic string tag_for(input int cmd, input int t, input int p, input bit rfirst);
        if (t < p) return "R2";
        if (cmd == 4'b0010) return "R3";
        if (cmd == 4'b0001) return "R5";
        if (cmd == 4'b0000) return "R6";
        return rfirst ? "R4/R7" : "R4/R8";
    endfunction

    task automatic check_cycle(input int t);
        int ca, cb;
        ca = exp_cmd(t, A_P, A_RP, A_RC, A_MRD, A_N, 1'b1);
        cb = exp_cmd(t, B_P, B_RP, B_RC, B_MRD, B_N, 1'b0);
        check({"A cmd ", tag_for(ca, t, A_P, 1'b1)}, {a_cs, a_ras, a_cas, a_we}, ca);
        check({"A addr ", tag_for(ca, t, A_P, 1'b1)}, a_addr, exp_addr(ca, A_CL, A_BT, A_BL, A_WS));
        check("A ba R1", a_ba, 0);
        check("A ready R7", a_rdy, exp_rdy(t, A_P, A_RP, A_RC, A_MRD, A_N, 1'b1));
        check("A cke/dqm R1", {a_cke, a_dqm}, 3);
        check({"B cmd ", tag_for(cb, t, B_P, 1'b0)}, {b_cs, b_ras, b_cas, b_we}, cb);
        check({"B addr ", tag_for(cb, t, B_P, 1'b0)}, b_addr, exp_addr(cb, B_CL, B_BT, B_BL, B_WS));
        check("B ba R1", b_ba, 0);
        check("B ready R8", b_rdy, exp_rdy(t, B_P, B_RP, B_RC, B_MRD, B_N, 1'b0));
        check("B cke/dqm R1", {b_cke, b_dqm}, 3);
    endtask

    task automatic check_reset_state(input string tag);
        check({tag, " A pins"}, {a_cke, a_dqm, a_cs, a_ras, a_cas, a_we}, 6'b110111);
        check({tag, " A ready"}, a_rdy, 0);
        check({tag, " A addr"}, a_addr, 0);
        check({tag, " B pins"}, {b_cke, b_dqm, b_cs, b_ras, b_cas, b_we}, 6'b110111);
        check({tag, " B ready"}, b_rdy, 0);
        check({tag, " B addr"}, b_addr, 0);
    endtask

    // hold reset for n cycles, checking the outputs each cycle
    task automatic do_reset(input int n, input string tag);
        @(posedge clk); #1 rst = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            check_reset_state(tag);
        end
        rst = 1'b0;
    endtask

    // compare cycles 0..upto-1 after reset release
    task automatic run_seq(input int upto);
        for (int t = 0; t < upto; t++) begin
            check_cycle(t);
            @(posedge clk); #1;
        end
    endtask

    initial begin
        do_reset(3, "R1 reset");
        run_seq(RUN_LEN);            // R2 R3 R4 R5 R6 R7 R8 R9 full pass
        do_reset(2, "R10 after ready");
        run_seq(A_P + 6);            // R10 cut mid-sequence
        do_reset(1, "R10 mid");
        run_seq(RUN_LEN);            // R10 full rerun after mid reset
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule